// File: doc/BRIEF.md
# Two-Halfword Long Branch Combiner

This block sits in the decode stage of a core that fetches 16-bit instruction halfwords. A long call with link is split across two consecutive halfwords. A leading half (the head) carries the upper part of the branch offset. A trailing half (the tail) carries the lower part and completes the call. The block recognises both halves. On the head it writes a partial address into the link register. On the tail it adds the rest of the offset to that partial address, raises a PC redirect and writes the return address into the link register. It also says whether the call changes the instruction-set state.

Every halfword arrives with a valid strobe, its own address and the current link-register value. All outputs are combinational and belong to the halfword presented in that cycle. One internal flag, plus the address of the head, records that a head has been accepted and that a tail is awaited. Rules on how the halves must pair are enforced: a broken pair raises a pairing-error flag, and a tail that breaks an encoding rule raises an undefined-instruction flag. In both cases the tail causes no redirect.

Top module: `long_branch_combiner`

## Requirements
- R1: After reset no head is pending, so a tail presented first is treated as unpaired.
- R2: Bits [15:13] equal to 111 mark a member of the family, and bits [12:11] select the form: 10 is a head, 11 is a tail that keeps the state, 01 is a tail that switches state. 00 is a plain branch and is not handled. A plain branch, or any other halfword, presented with no head pending drives every output low.
- R3: A head at address P writes the link register with P + 4 plus bits [10:0] sign-extended and shifted left by 12. It causes no redirect.
- R4: A paired state-keeping tail at address Q redirects to link_in plus bits [10:0] shifted left by 1. It writes the link register with Q + 2 with bit 0 set, and leaves switch_state low.
- R5: A paired state-switching tail computes the same sum with bits [1:0] cleared, writes the same link value as R4, and raises switch_state.
- R6: A state-switching tail with bit 0 set raises undef_instr, causes no redirect and no link write, and leaves no head pending.
- R7: A tail with no head pending raises pair_err and causes no redirect and no link write.
- R8: While a head is pending, a following valid halfword that is not a tail raises pair_err and leaves no head pending. If that halfword is a new head, its own link write still takes place and it becomes the pending head.
- R9: A tail whose address is not the pending head's address + 2 raises pair_err, causes no redirect, and clears the pending head.
- R10: Cycles with hw_valid low drive every output low and leave the pending head unchanged, so a head and a tail separated by idle cycles still pair.
- R11: The combined offset reaches both ends of its range, -2^22 and +2^22-2, with the correct target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_valid | input | 1 | The halfword on hw_data is presented this cycle |
| hw_data | input | 16 | Instruction halfword |
| hw_pc | input | 32 | Address of the presented halfword |
| link_in | input | 32 | Current link-register value |
| link_we | output | 1 | Write the link register this cycle |
| link_wdata | output | 32 | Link-register write value (zero when link_we is low) |
| redirect | output | 1 | Take the branch this cycle |
| target | output | 32 | Branch target (zero when redirect is low) |
| switch_state | output | 1 | The branch selects the other instruction-set state |
| undef_instr | output | 1 | Undefined encoding of a state-switching tail |
| pair_err | output | 1 | Head and tail pairing rule broken |

## Verification
The bench goes after the corners where a pair is almost right. These include a tail straight after reset, a head followed by a second head, a head followed by an unrelated halfword, a tail at the wrong address, and a head and tail split by idle cycles. A design that kept a stale pending head would redirect on an orphan tail. A design that cleared the flag on idle cycles would reject a legitimate split pair. The bench also drives the extreme offsets, which catch a sign extension taken from the wrong bit. It drives a state-switching tail that needs its low bits cleared, which a design that forgot the alignment would send to a misaligned target. Finally, it drives a state-switching tail with bit 0 set, which a design without the undefined check would follow as a call.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

   // Which member of the long-branch family a halfword is
   typedef enum logic [1:0] {
      FORM_OTHER     = 2'd0,
      FORM_HEAD      = 2'd1,
      FORM_TAIL_KEEP = 2'd2,
      FORM_TAIL_SWAP = 2'd3
   } lbc_form_e;

   // Opcode marking the family in the top three bits
   localparam logic [2:0] LBC_OPC = 3'b111;

   // Codes of the two-bit selector field
   localparam logic [1:0] SEL_HEAD = 2'b10;
   localparam logic [1:0] SEL_KEEP = 2'b11;
   localparam logic [1:0] SEL_SWAP = 2'b01;

endpackage

// File: rtl/lbc_decode.sv
module lbc_decode
   import lbc_pkg::*;
#(
   parameter int HW_W  = 16,
   parameter int OFF_W = 11
) (
   input  logic [HW_W-1:0]  hw,
   output lbc_form_e        form,
   output logic [OFF_W-1:0] off
);

   localparam int SEL_LO = OFF_W;
   localparam int SEL_HI = OFF_W + 1;
   localparam int OPC_LO = OFF_W + 2;

   generate
      if (HW_W != OFF_W + 5) begin : g_bad_width
         $error("lbc_decode: HW_W must equal OFF_W + 5");
      end
   endgenerate

   always_comb begin
      off  = hw[OFF_W-1:0];
      form = FORM_OTHER;
      if (hw[HW_W-1:OPC_LO] == LBC_OPC) begin
         case (hw[SEL_HI:SEL_LO])
            SEL_HEAD: form = FORM_HEAD;
            SEL_KEEP: form = FORM_TAIL_KEEP;
            SEL_SWAP: form = FORM_TAIL_SWAP;
            default:  form = FORM_OTHER;
         endcase
      end
   end

endmodule

// File: rtl/lbc_pair_track.sv
module lbc_pair_track
   import lbc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter bit CHECK_ADJ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  lbc_form_e         form,
   input  logic [ADDR_W-1:0] pc,
   output logic              paired,
   output logic              err
);

   logic pend_q;
   logic adj;

   generate
      if (CHECK_ADJ) begin : g_adj
         logic [ADDR_W-1:0] head_pc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               head_pc_q <= '0;
            else if (valid && form == FORM_HEAD)
               head_pc_q <= pc;
         end
         assign adj = (pc == head_pc_q + ADDR_W'(2));
      end else begin : g_no_adj
         assign adj = 1'b1;
      end
   endgenerate

   // Any valid halfword consumes the pending head; only a head sets it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (valid)
         pend_q <= (form == FORM_HEAD);
   end

   assign paired = pend_q && adj;

   always_comb begin
      err = 1'b0;
      if (valid) begin
         case (form)
            FORM_HEAD:  err = pend_q;
            FORM_OTHER: err = pend_q;
            default:    err = !paired;
         endcase
      end
   end

endmodule

// File: rtl/lbc_target.sv
module lbc_target #(
   parameter int ADDR_W     = 32,
   parameter int OFF_W      = 11,
   parameter int HEAD_SHIFT = 12
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] link_in,
   input  logic [OFF_W-1:0]  off,
   input  logic              swap,
   output logic [ADDR_W-1:0] head_link,
   output logic [ADDR_W-1:0] tail_target,
   output logic [ADDR_W-1:0] tail_link
);

   localparam int HEAD_EXT = ADDR_W - OFF_W - HEAD_SHIFT;
   localparam int TAIL_PAD = ADDR_W - OFF_W - 1;

   generate
      if (HEAD_SHIFT != OFF_W + 1) begin : g_bad_shift
         $error("lbc_target: HEAD_SHIFT must equal OFF_W + 1");
      end
      if (HEAD_EXT < 1) begin : g_bad_addr
         $error("lbc_target: ADDR_W too small for the combined offset");
      end
   endgenerate

   logic [ADDR_W-1:0] head_off;
   logic [ADDR_W-1:0] tail_off;
   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] pc_next;

   assign head_off  = {{HEAD_EXT{off[OFF_W-1]}}, off, {HEAD_SHIFT{1'b0}}};
   assign tail_off  = {{TAIL_PAD{1'b0}}, off, 1'b0};
   assign head_link = pc + ADDR_W'(4) + head_off;
   assign sum       = link_in + tail_off;
   assign pc_next   = pc + ADDR_W'(2);
   assign tail_link = {pc_next[ADDR_W-1:1], 1'b1};

   always_comb begin
      if (swap)
         tail_target = {sum[ADDR_W-1:2], 2'b00};
      else
         tail_target = sum;
   end

endmodule

// File: rtl/long_branch_combiner.sv
module long_branch_combiner
   import lbc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int HW_W      = 16,
   parameter int OFF_W     = 11,
   parameter bit CHECK_ADJ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_valid,
   input  logic [HW_W-1:0]   hw_data,
   input  logic [ADDR_W-1:0] hw_pc,
   input  logic [ADDR_W-1:0] link_in,
   output logic              link_we,
   output logic [ADDR_W-1:0] link_wdata,
   output logic              redirect,
   output logic [ADDR_W-1:0] target,
   output logic              switch_state,
   output logic              undef_instr,
   output logic              pair_err
);

   localparam int HEAD_SHIFT = OFF_W + 1;

   lbc_form_e         form;
   logic [OFF_W-1:0]  off;
   logic              paired;
   logic              trk_err;
   logic              is_tail;
   logic              swap;
   logic              bad_swap;
   logic              take;
   logic [ADDR_W-1:0] head_link;
   logic [ADDR_W-1:0] tail_target;
   logic [ADDR_W-1:0] tail_link;

   lbc_decode #(
      .HW_W  (HW_W),
      .OFF_W (OFF_W)
   ) u_decode (
      .hw   (hw_data),
      .form (form),
      .off  (off)
   );

   lbc_pair_track #(
      .ADDR_W    (ADDR_W),
      .CHECK_ADJ (CHECK_ADJ)
   ) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (hw_valid),
      .form   (form),
      .pc     (hw_pc),
      .paired (paired),
      .err    (trk_err)
   );

   lbc_target #(
      .ADDR_W     (ADDR_W),
      .OFF_W      (OFF_W),
      .HEAD_SHIFT (HEAD_SHIFT)
   ) u_target (
      .pc          (hw_pc),
      .link_in     (link_in),
      .off         (off),
      .swap        (swap),
      .head_link   (head_link),
      .tail_target (tail_target),
      .tail_link   (tail_link)
   );

   assign swap     = (form == FORM_TAIL_SWAP);
   assign is_tail  = (form == FORM_TAIL_KEEP) || swap;
   assign bad_swap = swap && off[0];
   assign take     = hw_valid && is_tail && paired && !bad_swap;

   always_comb begin
      link_we      = 1'b0;
      link_wdata   = '0;
      redirect     = 1'b0;
      target       = '0;
      switch_state = 1'b0;
      if (hw_valid && form == FORM_HEAD) begin
         link_we    = 1'b1;
         link_wdata = head_link;
      end else if (take) begin
         link_we      = 1'b1;
         link_wdata   = tail_link;
         redirect     = 1'b1;
         target       = tail_target;
         switch_state = swap;
      end
   end

   assign undef_instr = hw_valid && bad_swap;
   assign pair_err    = trk_err;

endmodule

// File: rtl/lbc_checker.sv
module lbc_checker #(
   parameter int ADDR_W = 32,
   parameter int HW_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hw_valid,
   input logic [HW_W-1:0]   hw_data,
   input logic [ADDR_W-1:0] hw_pc,
   input logic              link_we,
   input logic [ADDR_W-1:0] link_wdata,
   input logic              redirect,
   input logic [ADDR_W-1:0] target,
   input logic              switch_state,
   input logic              undef_instr,
   input logic              pair_err
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_valid |-> !(link_we || redirect || undef_instr || pair_err)); // R10

   AST_UNDEF_NO_CALL: assert property (@(posedge clk) disable iff (!rst_n)
      undef_instr |-> !redirect && !link_we); // R6

   AST_ERR_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      pair_err |-> !redirect); // R7

   AST_TAIL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> link_we && link_wdata == ((hw_pc + ADDR_W'(2)) | ADDR_W'(1))); // R4

   AST_SWAP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      switch_state |-> redirect && target[1:0] == 2'b00); // R5

   AST_HEAD_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_valid && hw_data[HW_W-1:HW_W-5] == 5'b11110) |-> link_we && !redirect); // R3

   AST_PLAIN_BRANCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_valid && hw_data[HW_W-1:HW_W-5] == 5'b11100) |-> !link_we && !redirect && !undef_instr); // R2

endmodule

bind long_branch_combiner lbc_checker #(
   .ADDR_W (ADDR_W),
   .HW_W   (HW_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hw_valid     (hw_valid),
   .hw_data      (hw_data),
   .hw_pc        (hw_pc),
   .link_we      (link_we),
   .link_wdata   (link_wdata),
   .redirect     (redirect),
   .target       (target),
   .switch_state (switch_state),
   .undef_instr  (undef_instr),
   .pair_err     (pair_err)
);

// File: tb/long_branch_combiner_tb.sv
module long_branch_combiner_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hw_valid = 1'b0;
   logic [15:0] hw_data = '0;
   logic [31:0] hw_pc = '0;
   logic [31:0] link_in = '0;
   logic        link_we;
   logic [31:0] link_wdata;
   logic        redirect;
   logic [31:0] target;
   logic        switch_state;
   logic        undef_instr;
   logic        pair_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   long_branch_combiner u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .hw_valid     (hw_valid),
      .hw_data      (hw_data),
      .hw_pc        (hw_pc),
      .link_in      (link_in),
      .link_we      (link_we),
      .link_wdata   (link_wdata),
      .redirect     (redirect),
      .target       (target),
      .switch_state (switch_state),
      .undef_instr  (undef_instr),
      .pair_err     (pair_err)
   );

   typedef struct packed {
      logic        we;
      logic [31:0] wdata;
      logic        rd;
      logic [31:0] tgt;
      logic        sw;
      logic        ud;
      logic        pe;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    total = 0;
   int    bad = 0;
   bit    finished = 1'b0;

   // Bench-side model state, built from the requirements
   bit          m_pend = 1'b0;
   logic [31:0] m_head_pc = '0;
   logic [31:0] m_link = '0;

   task automatic drive(input bit v, input logic [15:0] hw, input logic [31:0] pc, input string tag);
      exp_t e;
      logic [10:0] o;
      logic [4:0]  top;
      logic [31:0] s;
      bit          ok;
      @(posedge clk);
      #1;
      e = '0;
      hw_valid = v;
      hw_data = hw;
      hw_pc = pc;
      link_in = m_link;
      o = hw[10:0];
      top = hw[15:11];
      if (v) begin
         if (top == 5'b11110) begin
            e.we = 1'b1;
            e.wdata = pc + 32'd4 + {{9{o[10]}}, o, 12'b0};
            e.pe = m_pend;
            m_pend = 1'b1;
            m_head_pc = pc;
         end else if (top == 5'b11111 || top == 5'b11101) begin
            ok = m_pend && (pc == m_head_pc + 32'd2);
            e.ud = (top == 5'b11101) && hw[0];
            e.pe = !ok;
            if (ok && !e.ud) begin
               s = m_link + {20'b0, o, 1'b0};
               e.rd = 1'b1;
               e.we = 1'b1;
               e.wdata = (pc + 32'd2) | 32'd1;
               e.sw = (top == 5'b11101);
               e.tgt = e.sw ? {s[31:2], 2'b00} : s;
            end
            m_pend = 1'b0;
         end else begin
            e.pe = m_pend;
            m_pend = 1'b0;
         end
      end
      if (e.we) m_link = e.wdata;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input string tag);
      drive(1'b0, 16'h0000, 32'h0, tag);
   endtask

   // Monitor: compare each presented beat away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t  e;
            exp_t  a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {link_we, link_wdata, redirect, target, switch_state, undef_instr, pair_err};
            total++;
            if (a !== e) begin
               bad++;
               $display("FAIL %s: got we=%b wd=%h rd=%b tg=%h sw=%b ud=%b pe=%b exp we=%b wd=%h rd=%b tg=%h sw=%b ud=%b pe=%b",
                        t, a.we, a.wdata, a.rd, a.tgt, a.sw, a.ud, a.pe,
                        e.we, e.wdata, e.rd, e.tgt, e.sw, e.ud, e.pe);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: got running exp finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      idle("R1 reset outputs quiet");
      drive(1, 16'hF812, 32'h0000_0100, "R1 R7 tail right after reset");
      drive(1, 16'hE005, 32'h0000_0102, "R2 plain branch ignored");
      drive(1, 16'h4600, 32'h0000_0104, "R2 unrelated halfword ignored");

      drive(1, 16'hF001, 32'h0000_1000, "R3 head positive offset");
      drive(1, 16'hF810, 32'h0000_1002, "R4 keep-state tail");

      drive(1, 16'hF7FF, 32'h0000_8000, "R3 head negative offset");
      drive(1, 16'hE803, 32'h0000_8002, "R6 swap tail bit0 set");
      drive(1, 16'hF812, 32'h0000_8004, "R6 no head left after undef");

      drive(1, 16'hF002, 32'h0000_2002, "R3 head before swap tail");
      drive(1, 16'hE802, 32'h0000_2004, "R5 swap tail aligned target");

      drive(1, 16'hF3FF, 32'h0010_0000, "R11 head max offset");
      drive(1, 16'hFFFF, 32'h0010_0002, "R11 tail max offset");
      drive(1, 16'hF400, 32'h0080_0000, "R11 head min offset");
      drive(1, 16'hF800, 32'h0080_0002, "R11 tail min offset");

      drive(1, 16'hF010, 32'h0000_3000, "R10 head before gap");
      idle("R10 idle gap one");
      idle("R10 idle gap two");
      drive(1, 16'hF844, 32'h0000_3002, "R10 tail after gap pairs");

      drive(1, 16'hF020, 32'h0000_4000, "R8 first head");
      drive(1, 16'hF030, 32'h0000_4002, "R8 second head flagged");
      drive(1, 16'hF808, 32'h0000_4004, "R8 tail pairs with second head");

      drive(1, 16'hF001, 32'h0000_5000, "R8 head before stray halfword");
      drive(1, 16'h4600, 32'h0000_5002, "R8 stray halfword flagged");
      drive(1, 16'hF808, 32'h0000_5004, "R8 tail after stray unpaired");

      drive(1, 16'hF001, 32'h0000_0100, "R9 head at 0x100");
      drive(1, 16'hF808, 32'h0000_0200, "R9 tail at wrong address");
      drive(1, 16'hF808, 32'h0000_0102, "R9 head cleared by bad tail");

      idle("R10 final quiet");
      @(posedge clk);
      @(negedge clk);
      #1;
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule